// File: doc/BRIEF.md
# Keyboard Controller Host Command Decoder

This block is the processor-facing register interface of a legacy PC keyboard and auxiliary-device controller. The host reaches it through one byte-wide write path. A select bit chooses between the command port and the data port. A byte written to the command port is decoded at once. Depending on the byte, the block returns a reply, edits the mode register, status register or output-port register, drives the A20 gate or the reset request, or arms a pending target. When a target is armed, the next data-port byte goes to that target instead of to the keyboard.

Bytes that the controller itself produces are pushed toward the keyboard-side output queue through a one-cycle strobe. These are command replies, register readbacks and host-injected buffer bytes. A flag on the push marks bytes that should appear as coming from the auxiliary device. Bytes meant for the keyboard or for the mouse leave on two separate strobed outputs. The status register is presented continuously, so reading it has no side effects. The serial line protocol and the device models sit outside this block.

Top module: `kbd_ctrl_host`

## Requirements
- R1: After a synchronous active-low reset, the mode register is 0x03, the status register is 0x18 and the output port is 0xCF. As a result a20_gate is 1 and xlate_en is 0, and every strobe output is low.
- R2: A write with host_sel=1 is taken as a command byte. A write with host_sel=0 is taken as a data byte.
- R3: Command 0x20 pushes the current mode register. Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 push nothing and become the pending target. A later arming command replaces an earlier one.
- R4: A data byte is routed by the pending target, and the target then returns to none:
  - none: forwarded to the keyboard.
  - 0x60: loaded into the mode register.
  - 0xD2: pushed with push_aux=0.
  - 0xD3: pushed with push_aux=1.
  - 0xD1: written to the output port.
  - 0xD4: forwarded to the mouse.
- R5: Several commands produce a fixed reply or a readback:
  - 0xAA sets status bit 2 and pushes 0x55.
  - 0xA9 and 0xAB push 0x00.
  - 0xC0 pushes 0x80.
  - 0xD0 pushes the output-port register.
- R6: Four commands edit the mode register. 0xA7 sets mode bit 5 and 0xA8 clears it. 0xAD sets mode bit 4 and 0xAE clears it.
- R7: 0xDF sets output-port bit 1 and 0xDD clears it. a20_gate always equals output-port bit 1.
- R8: A data byte written to the output port replaces the whole register. If bit 0 of that byte is 0, the write raises sys_reset_req.
- R9: A command byte whose upper nibble is 0xF raises sys_reset_req when its bit 0 is 0. When its bit 0 is 1 it has no effect.
- R10: Command bytes not named in R3, R5, R6, R7 or R9 change no register, keep the pending target, and push nothing.
- R11: xlate_en equals mode bit 6.
- R12: Every effect of a write is visible in the cycle after the clock edge that accepts it. The push strobe, forward strobes and reset request are each one cycle wide per write, and at most one of push_valid, kbd_fwd_valid and aux_fwd_valid is high at a time.
- R13: push_aux is 1 only for bytes pushed through the 0xD3 target. All other pushes carry push_aux=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_sel | input | 1 | 1 selects the command port, 0 selects the data port |
| host_wdata | input | 8 | Byte written by the host |
| status_q | output | 8 | Status register, readable without side effects |
| push_valid | output | 1 | One-cycle strobe: a byte for the output queue |
| push_data | output | 8 | Byte pushed toward the output queue |
| push_aux | output | 1 | Pushed byte is tagged as auxiliary-device data |
| kbd_fwd_valid | output | 1 | One-cycle strobe: a byte forwarded to the keyboard |
| kbd_fwd_data | output | 8 | Byte forwarded to the keyboard |
| aux_fwd_valid | output | 1 | One-cycle strobe: a byte forwarded to the mouse |
| aux_fwd_data | output | 8 | Byte forwarded to the mouse |
| a20_gate | output | 1 | A20 gate level, equal to output-port bit 1 |
| xlate_en | output | 1 | Scan-code translation enable, equal to mode bit 6 |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench sweeps all 256 command bytes, each from a fresh reset, and runs the same fixed follow-up for every byte. That follow-up is a data write of 0x5A, a mode readback and an output-port readback. Together these show which bytes reply and with what, which ones arm a target and where the follow-up byte goes, and which ones change mode, status, A20 or reset. Because 0x5A has bit 0 clear and bits 1 and 6 set, one byte separates a mode load from an output-port write, and separates either of those from a forward. Directed sequences then cover three more cases: a command port versus data port write of the same byte, an unsupported command between arming and data, and the quiet cycle after each strobe.

// File: rtl/kbc_pkg.sv
// Shared definitions for the keyboard controller host interface.
// Assumes byte-wide host accesses; command codes are the values the host
// software issues, so they are fixed by behaviour rather than layout.
package kbc_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // Command codes whose values the host depends on
    localparam byte_t CMD_RD_MODE    = 8'h20;
    localparam byte_t CMD_WR_MODE    = 8'h60;
    localparam byte_t CMD_AUX_OFF    = 8'hA7;
    localparam byte_t CMD_AUX_ON     = 8'hA8;
    localparam byte_t CMD_AUX_TEST   = 8'hA9;
    localparam byte_t CMD_SELF_TEST  = 8'hAA;
    localparam byte_t CMD_KBD_TEST   = 8'hAB;
    localparam byte_t CMD_KBD_OFF    = 8'hAD;
    localparam byte_t CMD_KBD_ON     = 8'hAE;
    localparam byte_t CMD_RD_INPUT   = 8'hC0;
    localparam byte_t CMD_RD_OUTP    = 8'hD0;
    localparam byte_t CMD_WR_OUTP    = 8'hD1;
    localparam byte_t CMD_INJ_KBD    = 8'hD2;
    localparam byte_t CMD_INJ_AUX    = 8'hD3;
    localparam byte_t CMD_TO_MOUSE   = 8'hD4;
    localparam byte_t CMD_A20_OFF    = 8'hDD;
    localparam byte_t CMD_A20_ON     = 8'hDF;
    localparam logic [3:0] PULSE_NIBBLE = 4'hF;

    // Reply constants
    localparam byte_t REPLY_SELF_OK  = 8'h55;
    localparam byte_t REPLY_TEST_OK  = 8'h00;
    localparam byte_t REPLY_INPUT    = 8'h80;

    // Bit positions that neighbours decode
    localparam int MODE_KBD_OFF_BIT  = 4;
    localparam int MODE_AUX_OFF_BIT  = 5;
    localparam int MODE_XLATE_BIT    = 6;
    localparam int STAT_SELFTEST_BIT = 2;
    localparam int OUTP_NRESET_BIT   = 0;
    localparam int OUTP_A20_BIT      = 1;

    // Decoded command operations
    typedef enum logic [3:0] {
        OP_NONE,
        OP_PUSH_MODE,
        OP_ARM,
        OP_SET_MBIT,
        OP_CLR_MBIT,
        OP_PUSH_CONST,
        OP_SELF_TEST,
        OP_PUSH_OUTP,
        OP_A20_ON,
        OP_A20_OFF,
        OP_RESET
    } cmd_op_e;

    // Operation plus its argument (reply byte, mode mask or armed code)
    typedef struct packed {
        cmd_op_e op;
        byte_t   arg;
    } cmd_dec_t;

endpackage

// File: rtl/kbc_cmd_decode.sv
// Command byte classifier.
// Purely combinational: maps a command byte to an operation and argument.
// Assumes the caller qualifies the result with its own write strobe.
// Pulse commands (upper nibble all ones) fold onto reset or no-op by bit 0.
module kbc_cmd_decode
    import kbc_pkg::*;
(
    input  byte_t    cmd,
    output cmd_dec_t dec
);

    // Classify the command byte
    always_comb begin
        dec.op  = OP_NONE;
        dec.arg = '0;
        if (cmd[BYTE_W-1 -: 4] == PULSE_NIBBLE) begin
            dec.op = cmd[0] ? OP_NONE : OP_RESET;
        end else begin
            case (cmd)
                CMD_RD_MODE:   dec.op = OP_PUSH_MODE;
                CMD_WR_MODE,
                CMD_WR_OUTP,
                CMD_INJ_KBD,
                CMD_INJ_AUX,
                CMD_TO_MOUSE: begin
                    dec.op  = OP_ARM;
                    dec.arg = cmd;
                end
                CMD_AUX_OFF: begin
                    dec.op  = OP_SET_MBIT;
                    dec.arg = byte_t'(1) << MODE_AUX_OFF_BIT;
                end
                CMD_AUX_ON: begin
                    dec.op  = OP_CLR_MBIT;
                    dec.arg = byte_t'(1) << MODE_AUX_OFF_BIT;
                end
                CMD_KBD_OFF: begin
                    dec.op  = OP_SET_MBIT;
                    dec.arg = byte_t'(1) << MODE_KBD_OFF_BIT;
                end
                CMD_KBD_ON: begin
                    dec.op  = OP_CLR_MBIT;
                    dec.arg = byte_t'(1) << MODE_KBD_OFF_BIT;
                end
                CMD_AUX_TEST,
                CMD_KBD_TEST: begin
                    dec.op  = OP_PUSH_CONST;
                    dec.arg = REPLY_TEST_OK;
                end
                CMD_SELF_TEST: begin
                    dec.op  = OP_SELF_TEST;
                    dec.arg = REPLY_SELF_OK;
                end
                CMD_RD_INPUT: begin
                    dec.op  = OP_PUSH_CONST;
                    dec.arg = REPLY_INPUT;
                end
                CMD_RD_OUTP:   dec.op = OP_PUSH_OUTP;
                CMD_A20_ON:    dec.op = OP_A20_ON;
                CMD_A20_OFF:   dec.op = OP_A20_OFF;
                default:       dec.op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/kbc_data_router.sv
// Pending-target holder and data-byte router.
// Holds the armed write target between a command write and the next data
// write, steers the data byte, and registers the keyboard and mouse
// forward strobes. Assumes only one host write per cycle.
module kbc_data_router
    import kbc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_stb,
    input  cmd_dec_t dec,
    input  logic     data_stb,
    input  byte_t    wdata,
    output logic     load_mode,
    output logic     load_outp,
    output logic     data_push,
    output logic     data_push_aux,
    output logic     kbd_fwd_valid,
    output byte_t    kbd_fwd_data,
    output logic     aux_fwd_valid,
    output byte_t    aux_fwd_data
);

    byte_t pending_q;

    // Steer the current data byte by the armed target
    always_comb begin
        load_mode     = 1'b0;
        load_outp     = 1'b0;
        data_push     = 1'b0;
        data_push_aux = 1'b0;
        if (data_stb) begin
            case (pending_q)
                CMD_WR_MODE: load_mode = 1'b1;
                CMD_WR_OUTP: load_outp = 1'b1;
                CMD_INJ_KBD: data_push = 1'b1;
                CMD_INJ_AUX: begin
                    data_push     = 1'b1;
                    data_push_aux = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Arm on a target command, clear after any data byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
        end else if (data_stb) begin
            pending_q <= '0;
        end else if (cmd_stb && dec.op == OP_ARM) begin
            pending_q <= dec.arg;
        end
    end

    // Register the keyboard and mouse forward strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kbd_fwd_valid <= 1'b0;
            kbd_fwd_data  <= '0;
            aux_fwd_valid <= 1'b0;
            aux_fwd_data  <= '0;
        end else begin
            kbd_fwd_valid <= data_stb && (pending_q == '0);
            aux_fwd_valid <= data_stb && (pending_q == CMD_TO_MOUSE);
            if (data_stb) begin
                kbd_fwd_data <= wdata;
                aux_fwd_data <= wdata;
            end
        end
    end

endmodule

// File: rtl/kbc_state_regs.sv
// Mode, status and output-port registers with the reset-request pulse.
// Applies decoded command edits and routed data loads. Assumes a command
// edit and a data load never arrive in the same cycle.
module kbc_state_regs
    import kbc_pkg::*;
#(
    parameter byte_t MODE_RST   = 8'h03,
    parameter byte_t STATUS_RST = 8'h18,
    parameter byte_t OUTP_RST   = 8'hCF
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_stb,
    input  cmd_dec_t dec,
    input  logic     load_mode,
    input  logic     load_outp,
    input  byte_t    wdata,
    output byte_t    mode_q,
    output byte_t    status_q,
    output byte_t    outp_q,
    output logic     reset_req
);

    // Update the registers and the one-cycle reset request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_RST;
            status_q  <= STATUS_RST;
            outp_q    <= OUTP_RST;
            reset_req <= 1'b0;
        end else begin
            reset_req <= 1'b0;
            if (cmd_stb) begin
                case (dec.op)
                    OP_SET_MBIT:  mode_q <= mode_q | dec.arg;
                    OP_CLR_MBIT:  mode_q <= mode_q & ~dec.arg;
                    OP_SELF_TEST: status_q[STAT_SELFTEST_BIT] <= 1'b1;
                    OP_A20_ON:    outp_q[OUTP_A20_BIT] <= 1'b1;
                    OP_A20_OFF:   outp_q[OUTP_A20_BIT] <= 1'b0;
                    OP_RESET:     reset_req <= 1'b1;
                    default: ;
                endcase
            end
            if (load_mode) begin
                mode_q <= wdata;
            end
            if (load_outp) begin
                outp_q    <= wdata;
                reset_req <= ~wdata[OUTP_NRESET_BIT];
            end
        end
    end

endmodule

// File: rtl/kbc_push_stage.sv
// Output-queue push register.
// Picks the byte to push from either a command reply or a routed data byte
// and registers it with a one-cycle strobe. Assumes at most one source
// requests in a cycle.
module kbc_push_stage
    import kbc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_stb,
    input  cmd_dec_t dec,
    input  byte_t    mode_q,
    input  byte_t    outp_q,
    input  logic     data_push,
    input  logic     data_push_aux,
    input  byte_t    wdata,
    output logic     push_valid,
    output byte_t    push_data,
    output logic     push_aux
);

    logic  cmd_push;
    byte_t cmd_byte;

    // Choose the reply byte for a command
    always_comb begin
        cmd_push = 1'b0;
        cmd_byte = dec.arg;
        if (cmd_stb) begin
            case (dec.op)
                OP_PUSH_MODE: begin
                    cmd_push = 1'b1;
                    cmd_byte = mode_q;
                end
                OP_PUSH_OUTP: begin
                    cmd_push = 1'b1;
                    cmd_byte = outp_q;
                end
                OP_PUSH_CONST,
                OP_SELF_TEST: cmd_push = 1'b1;
                default: ;
            endcase
        end
    end

    // Register the push strobe, byte and auxiliary tag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_valid <= 1'b0;
            push_data  <= '0;
            push_aux   <= 1'b0;
        end else begin
            push_valid <= cmd_push || data_push;
            push_aux   <= data_push && data_push_aux;
            if (cmd_push) begin
                push_data <= cmd_byte;
            end else if (data_push) begin
                push_data <= wdata;
            end
        end
    end

endmodule

// File: rtl/kbd_ctrl_host.sv
// Host-side command decoder of a PC keyboard/auxiliary controller.
// Splits host writes into command and data strobes by the select bit, and
// ties together the decoder, router, register file and push stage.
// Assumes at most one host write per cycle; status reads have no effect.
module kbd_ctrl_host
    import kbc_pkg::*;
#(
    parameter logic [7:0] MODE_RST   = 8'h03,
    parameter logic [7:0] STATUS_RST = 8'h18,
    parameter logic [7:0] OUTP_RST   = 8'hCF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       host_sel,
    input  logic [7:0] host_wdata,
    output logic [7:0] status_q,
    output logic       push_valid,
    output logic [7:0] push_data,
    output logic       push_aux,
    output logic       kbd_fwd_valid,
    output logic [7:0] kbd_fwd_data,
    output logic       aux_fwd_valid,
    output logic [7:0] aux_fwd_data,
    output logic       a20_gate,
    output logic       xlate_en,
    output logic       sys_reset_req
);

    logic     cmd_stb;
    logic     data_stb;
    cmd_dec_t dec;
    logic     load_mode;
    logic     load_outp;
    logic     data_push;
    logic     data_push_aux;
    byte_t    mode_q;
    byte_t    outp_q;

    // Split the host write by port
    assign cmd_stb  = host_wr &&  host_sel;
    assign data_stb = host_wr && !host_sel;

    kbc_cmd_decode u_decode (
        .cmd (host_wdata),
        .dec (dec)
    );

    kbc_data_router u_router (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_stb       (cmd_stb),
        .dec           (dec),
        .data_stb      (data_stb),
        .wdata         (host_wdata),
        .load_mode     (load_mode),
        .load_outp     (load_outp),
        .data_push     (data_push),
        .data_push_aux (data_push_aux),
        .kbd_fwd_valid (kbd_fwd_valid),
        .kbd_fwd_data  (kbd_fwd_data),
        .aux_fwd_valid (aux_fwd_valid),
        .aux_fwd_data  (aux_fwd_data)
    );

    kbc_state_regs #(
        .MODE_RST   (MODE_RST),
        .STATUS_RST (STATUS_RST),
        .OUTP_RST   (OUTP_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_stb   (cmd_stb),
        .dec       (dec),
        .load_mode (load_mode),
        .load_outp (load_outp),
        .wdata     (host_wdata),
        .mode_q    (mode_q),
        .status_q  (status_q),
        .outp_q    (outp_q),
        .reset_req (sys_reset_req)
    );

    kbc_push_stage u_push (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_stb       (cmd_stb),
        .dec           (dec),
        .mode_q        (mode_q),
        .outp_q        (outp_q),
        .data_push     (data_push),
        .data_push_aux (data_push_aux),
        .wdata         (host_wdata),
        .push_valid    (push_valid),
        .push_data     (push_data),
        .push_aux      (push_aux)
    );

    // Drive the side-band levels from the registers
    assign a20_gate = outp_q[OUTP_A20_BIT];
    assign xlate_en = mode_q[MODE_XLATE_BIT];

endmodule

// File: rtl/kbd_ctrl_host_chk.sv
// Port-level checker for kbd_ctrl_host, attached by bind.
// Relates output strobes and levels to the host writes that cause them.
module kbd_ctrl_host_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic       host_sel,
    input logic [7:0] status_q,
    input logic       push_valid,
    input logic       kbd_fwd_valid,
    input logic       aux_fwd_valid,
    input logic       a20_gate,
    input logic       xlate_en,
    input logic       sys_reset_req
);

    p_strobes_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_valid, kbd_fwd_valid, aux_fwd_valid}));

    p_push_follows_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> $past(host_wr));

    p_fwd_follows_data_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_fwd_valid || aux_fwd_valid) |-> $past(host_wr && !host_sel));

    p_reset_follows_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(host_wr));

    p_status_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_sel) |=> $stable(status_q));

    p_a20_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(a20_gate));

    p_xlate_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && !host_sel) |=> $stable(xlate_en));

endmodule

bind kbd_ctrl_host kbd_ctrl_host_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr       (host_wr),
    .host_sel      (host_sel),
    .status_q      (status_q),
    .push_valid    (push_valid),
    .kbd_fwd_valid (kbd_fwd_valid),
    .aux_fwd_valid (aux_fwd_valid),
    .a20_gate      (a20_gate),
    .xlate_en      (xlate_en),
    .sys_reset_req (sys_reset_req)
);

// File: tb/kbd_ctrl_host_tb_top.sv
// Bench for kbd_ctrl_host: sweeps every command byte from reset with a
// fixed follow-up, then runs directed sequences for port select, pending
// retention and strobe width.
module kbd_ctrl_host_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] PROBE = 8'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_sel = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] status_q;
    logic       push_valid;
    logic [7:0] push_data;
    logic       push_aux;
    logic       kbd_fwd_valid;
    logic [7:0] kbd_fwd_data;
    logic       aux_fwd_valid;
    logic [7:0] aux_fwd_data;
    logic       a20_gate;
    logic       xlate_en;
    logic       sys_reset_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kbd_ctrl_host dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_wr       (host_wr),
        .host_sel      (host_sel),
        .host_wdata    (host_wdata),
        .status_q      (status_q),
        .push_valid    (push_valid),
        .push_data     (push_data),
        .push_aux      (push_aux),
        .kbd_fwd_valid (kbd_fwd_valid),
        .kbd_fwd_data  (kbd_fwd_data),
        .aux_fwd_valid (aux_fwd_valid),
        .aux_fwd_data  (aux_fwd_data),
        .a20_gate      (a20_gate),
        .xlate_en      (xlate_en),
        .sys_reset_req (sys_reset_req)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        host_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One write; returns at the negedge after the accepting posedge
    task automatic wr(input logic sel, input logic [7:0] b);
        host_wr = 1'b1;
        host_sel = sel;
        host_wdata = b;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    // Expect exactly one push of b with tag aux, no forwards
    task automatic expect_push(input string req, input logic [7:0] b, input logic aux);
        check({req, " push_valid"}, push_valid, 1);
        check({req, " push_data"}, push_data, b);
        check({req, " push_aux"}, push_aux, aux);
        check({req, " no kbd fwd"}, kbd_fwd_valid, 0);
        check({req, " no aux fwd"}, aux_fwd_valid, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        do_reset();
        check("R1 status", status_q, 8'h18);
        check("R1 a20", a20_gate, 1);
        check("R1 xlate", xlate_en, 0);
        check("R1 reset_req", sys_reset_req, 0);
        check("R1 strobes", {push_valid, kbd_fwd_valid, aux_fwd_valid}, 0);
        wr(1'b1, 8'h20);
        expect_push("R1 mode readback", 8'h03, 1'b0);
        wr(1'b1, 8'hD0);
        expect_push("R1 outport readback", 8'hCF, 1'b0);

        // Sweep of all command bytes
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cmd;
            logic [7:0] em, es, eo, pend;
            logic       ep, erst;
            logic [7:0] epd;
            cmd  = 8'(c);
            em   = 8'h03;
            es   = 8'h18;
            eo   = 8'hCF;
            pend = 8'h00;
            ep   = 1'b0;
            epd  = 8'h00;
            erst = 1'b0;
            if (cmd[7:4] == 4'hF) begin
                erst = ~cmd[0];                       // R9
            end else begin
                case (cmd)
                    8'h20: begin ep = 1'b1; epd = em; end          // R3
                    8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4: pend = cmd; // R3
                    8'hA7: em = em | 8'h20;                          // R6
                    8'hA8: em = em & ~8'h20;
                    8'hAD: em = em | 8'h10;
                    8'hAE: em = em & ~8'h10;
                    8'hA9, 8'hAB: begin ep = 1'b1; epd = 8'h00; end // R5
                    8'hAA: begin ep = 1'b1; epd = 8'h55; es = es | 8'h04; end
                    8'hC0: begin ep = 1'b1; epd = 8'h80; end
                    8'hD0: begin ep = 1'b1; epd = eo; end
                    8'hDF: eo = eo | 8'h02;                          // R7
                    8'hDD: eo = eo & ~8'h02;
                    default: ;                                       // R10
                endcase
            end

            do_reset();
            wr(1'b1, cmd);
            check("R3 R5 R10 cmd push_valid", push_valid, ep);
            if (ep) check("R5 cmd push_data", push_data, epd);
            check("R13 cmd push_aux", push_aux, 0);
            check("R2 cmd no fwd", {kbd_fwd_valid, aux_fwd_valid}, 0);
            check("R9 cmd reset_req", sys_reset_req, erst);
            check("R5 R10 status", status_q, es);
            check("R7 a20", a20_gate, eo[1]);
            idle();
            check("R12 strobes clear", {push_valid, kbd_fwd_valid, aux_fwd_valid, sys_reset_req}, 0);

            // Follow-up data byte routed by the armed target (R4)
            wr(1'b0, PROBE);
            case (pend)
                8'h00: begin
                    check("R4 kbd fwd", kbd_fwd_valid, 1);
                    check("R4 kbd data", kbd_fwd_data, PROBE);
                    check("R4 kbd no push", {push_valid, aux_fwd_valid}, 0);
                end
                8'h60: begin
                    em = PROBE;
                    check("R4 mode load quiet", {push_valid, kbd_fwd_valid, aux_fwd_valid}, 0);
                end
                8'hD2: expect_push("R4 R13 inject kbd", PROBE, 1'b0);
                8'hD3: expect_push("R4 R13 inject aux", PROBE, 1'b1);
                8'hD1: begin
                    eo = PROBE;
                    check("R8 outport reset_req", sys_reset_req, 1);
                end
                8'hD4: begin
                    check("R4 mouse fwd", aux_fwd_valid, 1);
                    check("R4 mouse data", aux_fwd_data, PROBE);
                    check("R4 mouse no push", {push_valid, kbd_fwd_valid}, 0);
                end
                default: ;
            endcase
            if (pend != 8'hD1) check("R8 no reset_req", sys_reset_req, 0);
            check("R11 xlate", xlate_en, em[6]);
            check("R7 R8 a20 level", a20_gate, eo[1]);

            wr(1'b1, 8'h20);
            expect_push("R3 R6 mode readback", em, 1'b0);
            wr(1'b1, 8'hD0);
            expect_push("R5 R7 R8 outport readback", eo, 1'b0);
            // Pending cleared: next data byte reaches the keyboard (R4)
            wr(1'b0, 8'h11);
            check("R4 pending cleared", kbd_fwd_valid, 1);
        end

        // R2: same byte on the data port is forwarded, not decoded
        do_reset();
        wr(1'b0, 8'h20);
        check("R2 data port fwd", kbd_fwd_valid, 1);
        check("R2 data port byte", kbd_fwd_data, 8'h20);
        check("R2 data port no push", push_valid, 0);

        // R10: unsupported command keeps the armed target
        do_reset();
        wr(1'b1, 8'h60);
        wr(1'b1, 8'h01);
        check("R10 unsupported no push", push_valid, 0);
        wr(1'b0, 8'h44);
        check("R10 kept target no fwd", kbd_fwd_valid, 0);
        wr(1'b1, 8'h20);
        expect_push("R10 kept target mode", 8'h44, 1'b0);

        // R3: a later arming command replaces an earlier one
        do_reset();
        wr(1'b1, 8'h60);
        wr(1'b1, 8'hD4);
        wr(1'b0, 8'h77);
        check("R3 rearm mouse fwd", aux_fwd_valid, 1);
        check("R3 rearm data", aux_fwd_data, 8'h77);
        wr(1'b1, 8'h20);
        expect_push("R3 rearm mode untouched", 8'h03, 1'b0);

        // R8: output-port write with bit 0 set gives no reset, one-cycle pulse width (R12)
        do_reset();
        wr(1'b1, 8'hD1);
        wr(1'b0, 8'h01);
        check("R8 no reset bit0=1", sys_reset_req, 0);
        check("R8 a20 low", a20_gate, 0);
        wr(1'b1, 8'hFE);
        check("R9 FE reset", sys_reset_req, 1);
        idle();
        check("R12 reset one cycle", sys_reset_req, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule